// File: doc/BRIEF.md
# Instruction-Boundary Event Priority Resolver

This block arbitrates all events that can interrupt or fault an in-order core at an instruction boundary. It collects interrupt requests, debug conditions, fetch, decode and operand-transfer faults, and coprocessor conditions. It gates the maskable ones with the architectural control bits. When the core pulses the boundary strobe, it names exactly one winner as a 4-bit cause code. The code is the event's priority level, so a lower code means a higher priority.

The cause leaves the block on a valid/ready handshake. `cause_valid` rises in the cycle after an accepted boundary. It then holds, with `cause_code` stable, until the consumer raises `cause_ready`. While a cause is outstanding the block applies back-pressure: boundary strobes are ignored, so each execution attempt yields one event.

Interrupt requests are remembered until their own cause is handed off. Fault and debug flags are remembered only for the current attempt, and the restart pulse clears them. The core then retries the instruction, and any faults that still apply are raised again.

Top module: `evt_prio_resolver`

## Requirements
- R1: An asynchronous active-low reset forces `cause_valid` to 0 and `cause_code` to 0 at once, and it clears all remembered requests and flags.
- R2: At a boundary with no cause outstanding, `cause_valid` is 1 in the next cycle, and `cause_code` is the lowest-numbered eligible event. The codes are:
  - 1: system-management interrupt
  - 2: debug condition from the previous instruction
  - 3: breakpoint for the next instruction
  - 4: non-maskable interrupt
  - 5: maskable interrupt
  - 6: fetch fault
  - 7: decode fault
  - 8: WAIT device-not-available
  - 9: ESC device-not-available
  - 10: floating-point error
  - 11: segmentation fault
  - 12: page fault
  - 13: alignment fault
- R3: A boundary with no eligible event leaves `cause_valid` at 0.
- R4: A system-management request wins over every other event, and a non-maskable request wins over a maskable one at the same boundary.
- R5: A maskable request is eligible only while `ctl_ie` is 1. While `ctl_ie` is 0 it stays pending and is not lost.
- R6: Code 8 needs `wait_op`, `ctl_ts` and `ctl_mp` all at 1. Code 9 needs `esc_op` with `ctl_em` or `ctl_ts` at 1. Code 10 needs `fp_unmasked` with `ctl_ne` at 1.
- R7: While `cause_valid` is 1 and `cause_ready` is 0, the valid and the code hold and boundary strobes have no effect. A cycle with both at 1 drops `cause_valid` in the next cycle.
- R8: Requests on `smi_req`, `nmi_req` and `intr_req` are remembered from any cycle. Handing off a cause clears only the request that matches its code. A request asserted in the same cycle stays pending.
- R9: Fault and debug flags (codes 2, 3, 6, 7, 11, 12, 13) are remembered from any cycle until `restart` is pulsed. A flag input that is high in the restart cycle is kept.
- R10: A handed-off fault is reported again at the next boundary if no restart came between, and only one cause is issued per boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boundary | input | 1 | Instruction-boundary strobe |
| restart | input | 1 | Retry pulse; clears per-attempt flags |
| smi_req | input | 1 | System-management interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| intr_req | input | 1 | Maskable interrupt request |
| dbg_prev | input | 1 | Debug trap/fault from previous instruction |
| dbg_next | input | 1 | Breakpoint on next instruction |
| flt_fetch | input | 1 | Fault fetching next instruction |
| flt_decode | input | 1 | Fault decoding instruction |
| wait_op | input | 1 | Current instruction is WAIT |
| esc_op | input | 1 | Current instruction is a coprocessor escape |
| fp_unmasked | input | 1 | Unmasked floating-point exception pending |
| flt_seg | input | 1 | Segmentation fault on operand transfer |
| flt_page | input | 1 | Page fault on operand transfer |
| flt_align | input | 1 | Alignment check fault |
| ctl_ie | input | 1 | Interrupt-enable flag |
| ctl_ts | input | 1 | Task-switched flag |
| ctl_mp | input | 1 | Monitor-coprocessor flag |
| ctl_em | input | 1 | Emulate-coprocessor flag |
| ctl_ne | input | 1 | Native floating-point error reporting flag |
| cause_ready | input | 1 | Consumer accepts the cause |
| cause_valid | output | 1 | Cause is present |
| cause_code | output | 4 | Encoded cause (priority level) |

## Verification
The assertions assume that every input is synchronous, free of X and stable around the rising edge. The control bits count only in the cycle the boundary is taken, so they may change freely between boundaries. The bench changes all inputs just after the falling edge, and it draws every bit from two-valued random or directed values, keeping requests sparse enough that each priority level wins some boundaries. Boundary and ready arrive at arbitrary spacing, including together with a pending cause, so the back-pressure and hand-off rules are exercised.

// File: rtl/evt_prio_pkg.sv
package evt_prio_pkg;
  localparam int NUM_LVL = 14;
  localparam int CODE_W  = $clog2(NUM_LVL);
  localparam int N_INT   = 3;   // 0 smi, 1 nmi, 2 intr
  localparam int N_FLT   = 7;   // 0 dbg_prev, 1 dbg_next, 2 fetch, 3 decode, 4 seg, 5 page, 6 align

  typedef enum logic [CODE_W-1:0] {
    LVL_RESET    = 4'd0,
    LVL_SMI      = 4'd1,
    LVL_DBG_PREV = 4'd2,
    LVL_DBG_NEXT = 4'd3,
    LVL_NMI      = 4'd4,
    LVL_INTR     = 4'd5,
    LVL_FETCH    = 4'd6,
    LVL_DECODE   = 4'd7,
    LVL_WAIT_DNA = 4'd8,
    LVL_ESC_DNA  = 4'd9,
    LVL_FPERR    = 4'd10,
    LVL_SEG      = 4'd11,
    LVL_PAGE     = 4'd12,
    LVL_ALIGN    = 4'd13
  } lvl_e;
endpackage

// File: rtl/evt_sticky.sv
module evt_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= (q_o[g] & ~clr_i[g]) | set_i[g];
    end
  end
endmodule

// File: rtl/evt_gate.sv
module evt_gate
  import evt_prio_pkg::*;
(
  input  logic [N_INT-1:0]   int_eff,
  input  logic [N_FLT-1:0]   flt_eff,
  input  logic               wait_op,
  input  logic               esc_op,
  input  logic               fp_unmasked,
  input  logic               ctl_ie,
  input  logic               ctl_ts,
  input  logic               ctl_mp,
  input  logic               ctl_em,
  input  logic               ctl_ne,
  output logic [NUM_LVL-1:0] req_o
);
  always_comb begin
    req_o               = '0;
    req_o[LVL_SMI]      = int_eff[0];
    req_o[LVL_DBG_PREV] = flt_eff[0];
    req_o[LVL_DBG_NEXT] = flt_eff[1];
    req_o[LVL_NMI]      = int_eff[1];
    req_o[LVL_INTR]     = int_eff[2] & ctl_ie;
    req_o[LVL_FETCH]    = flt_eff[2];
    req_o[LVL_DECODE]   = flt_eff[3];
    req_o[LVL_WAIT_DNA] = wait_op & ctl_ts & ctl_mp;
    req_o[LVL_ESC_DNA]  = esc_op & (ctl_em | ctl_ts);
    req_o[LVL_FPERR]    = fp_unmasked & ctl_ne;
    req_o[LVL_SEG]      = flt_eff[4];
    req_o[LVL_PAGE]     = flt_eff[5];
    req_o[LVL_ALIGN]    = flt_eff[6];
  end
endmodule

// File: rtl/evt_pick.sv
module evt_pick #(
  parameter int N  = 14,
  parameter int CW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [CW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CW'(i);
    end
  end
endmodule

// File: rtl/evt_prio_resolver.sv
module evt_prio_resolver
  import evt_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              restart,
  input  logic              smi_req,
  input  logic              nmi_req,
  input  logic              intr_req,
  input  logic              dbg_prev,
  input  logic              dbg_next,
  input  logic              flt_fetch,
  input  logic              flt_decode,
  input  logic              wait_op,
  input  logic              esc_op,
  input  logic              fp_unmasked,
  input  logic              flt_seg,
  input  logic              flt_page,
  input  logic              flt_align,
  input  logic              ctl_ie,
  input  logic              ctl_ts,
  input  logic              ctl_mp,
  input  logic              ctl_em,
  input  logic              ctl_ne,
  input  logic              cause_ready,
  output logic              cause_valid,
  output logic [CODE_W-1:0] cause_code
);
  logic [N_INT-1:0]   int_in, int_q, int_clr, int_eff;
  logic [N_FLT-1:0]   flt_in, flt_q, flt_eff;
  logic [NUM_LVL-1:0] req_vec;
  logic               req_any;
  logic [CODE_W-1:0]  req_idx;
  logic               handoff;

  assign int_in  = {intr_req, nmi_req, smi_req};
  assign flt_in  = {flt_align, flt_page, flt_seg, flt_decode, flt_fetch, dbg_next, dbg_prev};
  assign handoff = cause_valid & cause_ready;

  // clear only the interrupt whose cause is being handed off
  assign int_clr = {handoff && (cause_code == LVL_INTR),
                    handoff && (cause_code == LVL_NMI),
                    handoff && (cause_code == LVL_SMI)};

  evt_sticky #(.W(N_INT)) u_int_pend (
    .clk(clk), .rst_n(rst_n), .set_i(int_in), .clr_i(int_clr), .q_o(int_q)
  );

  evt_sticky #(.W(N_FLT)) u_flt_pend (
    .clk(clk), .rst_n(rst_n), .set_i(flt_in), .clr_i({N_FLT{restart}}), .q_o(flt_q)
  );

  // same-cycle inputs join the remembered ones
  assign int_eff = int_q | int_in;
  assign flt_eff = flt_q | flt_in;

  evt_gate u_gate (
    .int_eff(int_eff), .flt_eff(flt_eff),
    .wait_op(wait_op), .esc_op(esc_op), .fp_unmasked(fp_unmasked),
    .ctl_ie(ctl_ie), .ctl_ts(ctl_ts), .ctl_mp(ctl_mp),
    .ctl_em(ctl_em), .ctl_ne(ctl_ne),
    .req_o(req_vec)
  );

  evt_pick #(.N(NUM_LVL), .CW(CODE_W)) u_pick (
    .req_i(req_vec), .any_o(req_any), .idx_o(req_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_valid <= 1'b0;
      cause_code  <= LVL_RESET;
    end else if (cause_valid) begin
      if (cause_ready) cause_valid <= 1'b0;
    end else if (boundary && req_any) begin
      cause_valid <= 1'b1;
      cause_code  <= req_idx;
    end
  end
endmodule

// File: rtl/evt_prio_chk.sv
module evt_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary,
  input logic       cause_ready,
  input logic       cause_valid,
  input logic [3:0] cause_code,
  input logic       smi_req,
  input logic       ctl_ie,
  input logic       ctl_ts,
  input logic       ctl_mp,
  input logic       req_any
);
  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> (cause_code >= 4'd1 && cause_code <= 4'd13));

  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !cause_valid && !req_any) |=> !cause_valid);

  p_smi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !cause_valid && smi_req) |=> (cause_valid && cause_code == 4'd1));

  p_intr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && !$past(cause_valid) && cause_code == 4'd5) |-> $past(ctl_ie));

  p_wait_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && !$past(cause_valid) && cause_code == 4'd8) |-> $past(ctl_ts && ctl_mp));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && !cause_ready) |=> (cause_valid && $stable(cause_code)));

  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_valid && cause_ready) |=> !cause_valid);
endmodule

bind evt_prio_resolver evt_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .cause_ready(cause_ready),
  .cause_valid(cause_valid), .cause_code(cause_code), .smi_req(smi_req),
  .ctl_ie(ctl_ie), .ctl_ts(ctl_ts), .ctl_mp(ctl_mp), .req_any(req_any)
);

// File: tb/test_evt_prio_resolver.sv
module test_evt_prio_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, restart = 0, smi_req = 0, nmi_req = 0, intr_req = 0;
  logic dbg_prev = 0, dbg_next = 0, flt_fetch = 0, flt_decode = 0;
  logic wait_op = 0, esc_op = 0, fp_unmasked = 0, flt_seg = 0, flt_page = 0, flt_align = 0;
  logic ctl_ie = 0, ctl_ts = 0, ctl_mp = 0, ctl_em = 0, ctl_ne = 0, cause_ready = 0;
  logic       cause_valid;
  logic [3:0] cause_code;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R2";

  // reference state
  bit m_valid;
  int m_code;
  bit m_smi, m_nmi, m_intr;
  bit [6:0] m_flt;

  always #5 clk = ~clk;

  evt_prio_resolver i_evt_prio_resolver (.*);

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic idle();
    {boundary, restart, smi_req, nmi_req, intr_req, dbg_prev, dbg_next, flt_fetch,
     flt_decode, wait_op, esc_op, fp_unmasked, flt_seg, flt_page, flt_align, cause_ready} = '0;
  endtask

  function automatic int pick(bit [13:0] r);
    for (int i = 1; i < 14; i++) if (r[i]) return i;
    return 0;
  endfunction

  task automatic model_reset();
    m_valid = 0; m_code = 0; m_smi = 0; m_nmi = 0; m_intr = 0; m_flt = '0;
  endtask

  // inputs already driven; advance one clock, then compare at the falling edge
  task automatic step();
    bit [13:0] r;
    bit es, en, ei, ho;
    bit [6:0] fi, fe;
    fi = {flt_align, flt_page, flt_seg, flt_decode, flt_fetch, dbg_next, dbg_prev};
    fe = m_flt | fi;
    es = m_smi | smi_req; en = m_nmi | nmi_req; ei = m_intr | intr_req;
    r = '0;
    r[1] = es; r[2] = fe[0]; r[3] = fe[1]; r[4] = en; r[5] = ei & ctl_ie;
    r[6] = fe[2]; r[7] = fe[3]; r[8] = wait_op & ctl_ts & ctl_mp;
    r[9] = esc_op & (ctl_em | ctl_ts); r[10] = fp_unmasked & ctl_ne;
    r[11] = fe[4]; r[12] = fe[5]; r[13] = fe[6];
    ho = m_valid & cause_ready;
    m_smi  = (m_smi  & !(ho && m_code == 1)) | smi_req;
    m_nmi  = (m_nmi  & !(ho && m_code == 4)) | nmi_req;
    m_intr = (m_intr & !(ho && m_code == 5)) | intr_req;
    m_flt  = (restart ? 7'd0 : m_flt) | fi;
    if (m_valid) begin
      if (cause_ready) m_valid = 0;
    end else if (boundary && r != 0) begin
      m_valid = 1; m_code = pick(r);
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(cause_valid), int'(m_valid));
    if (m_valid) check({tag, " code"}, int'(cause_code), m_code);
    idle();
  endtask

  task automatic bnd();
    boundary = 1; step();
  endtask

  task automatic take();
    cause_ready = 1; step();
  endtask

  initial begin
    int unused;
    unused = $urandom(32'h5eed_1234);
    model_reset();
    idle();
    #12;
    // R1: reset state
    check("R1 valid", int'(cause_valid), 0);
    check("R1 code", int'(cause_code), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    tag = "R3"; bnd();                                 // nothing eligible
    tag = "R5"; ctl_ie = 0; intr_req = 1; boundary = 1; step();  // masked, stays pending
    ctl_ie = 1; bnd();                                 // pending maskable now wins
    check("R5 code5", int'(cause_code), 5);
    take();
    tag = "R4"; nmi_req = 1; intr_req = 1; boundary = 1; step();
    check("R4 nmi over intr", int'(cause_code), 4);
    take();
    bnd(); take();                                     // R8: intr still pending
    tag = "R4"; smi_req = 1; dbg_prev = 1; flt_align = 1; boundary = 1; step();
    check("R4 smi first", int'(cause_code), 1);
    tag = "R7"; boundary = 1; nmi_req = 1; step();     // held, boundary ignored
    check("R7 hold", int'(cause_code), 1);
    take();
    tag = "R8"; bnd(); check("R8 next is dbg", int'(cause_code), 2); take();
    restart = 1; step();
    tag = "R8"; bnd(); check("R8 nmi remembered", int'(cause_code), 4); take();
    tag = "R6"; ctl_ie = 0;
    wait_op = 1; ctl_ts = 1; ctl_mp = 0; boundary = 1; step();
    check("R6 wait blocked", int'(cause_valid), 0);
    wait_op = 1; ctl_mp = 1; boundary = 1; step(); check("R6 wait", int'(cause_code), 8); take();
    ctl_ts = 0; ctl_mp = 0; esc_op = 1; boundary = 1; step();
    check("R6 esc blocked", int'(cause_valid), 0);
    esc_op = 1; ctl_em = 1; boundary = 1; step(); check("R6 esc", int'(cause_code), 9); take();
    ctl_em = 0; fp_unmasked = 1; ctl_ne = 0; boundary = 1; step();
    check("R6 fp blocked", int'(cause_valid), 0);
    fp_unmasked = 1; ctl_ne = 1; boundary = 1; step(); check("R6 fp", int'(cause_code), 10); take();
    tag = "R9"; flt_seg = 1; step(); flt_page = 1; step();
    bnd(); check("R9 seg", int'(cause_code), 11); take();
    tag = "R10"; bnd(); check("R10 retry same", int'(cause_code), 11); take();
    tag = "R9"; restart = 1; flt_page = 1; step();     // page kept by same-cycle input
    bnd(); check("R9 page kept", int'(cause_code), 12); take();
    restart = 1; step(); bnd();
    check("R9 cleared", int'(cause_valid), 0);

    // random phase
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      boundary    = ($urandom_range(0, 2) == 0);
      cause_ready = ($urandom_range(0, 2) == 0);
      restart     = ($urandom_range(0, 7) == 0);
      smi_req     = ($urandom_range(0, 63) == 0);
      nmi_req     = ($urandom_range(0, 31) == 0);
      intr_req    = ($urandom_range(0, 15) == 0);
      dbg_prev    = ($urandom_range(0, 47) == 0);
      dbg_next    = ($urandom_range(0, 47) == 0);
      flt_fetch   = ($urandom_range(0, 31) == 0);
      flt_decode  = ($urandom_range(0, 31) == 0);
      wait_op     = ($urandom_range(0, 7) == 0);
      esc_op      = ($urandom_range(0, 7) == 0);
      fp_unmasked = ($urandom_range(0, 7) == 0);
      flt_seg     = ($urandom_range(0, 23) == 0);
      flt_page    = ($urandom_range(0, 23) == 0);
      flt_align   = ($urandom_range(0, 23) == 0);
      {ctl_ie, ctl_ts, ctl_mp, ctl_em, ctl_ne} = 5'($urandom);
      step();
    end

    // R1: asynchronous reset mid-cycle with a cause outstanding
    smi_req = 1; boundary = 1; tag = "R1"; step();
    #2 rst_n = 0; #1;
    check("R1 async valid", int'(cause_valid), 0);
    check("R1 async code", int'(cause_code), 0);
    model_reset();
    @(negedge clk); rst_n = 1;
    bnd(); check("R1 pending cleared", int'(cause_valid), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule